// File: doc/BRIEF.md
# Gated Eight-Channel DAC Code Register Bank

This block holds the digital codes for eight digital-to-analog converter channels and decides when those codes reach the converters. A simple register bus writes a 16-bit code register per channel. The bus also writes a 32-bit gating control word, which holds a load-inhibit bit and an output-enable bit, and an interrupt control word. The block drives a 14-bit code and a one-cycle update strobe per channel. The code-to-voltage mapping is V = code / 16384 × 20 − 10 volts, so code 0x2000 is the 0 V (ground) code.

A three-state gating machine tracks what the two control bits allow. The states are GM_PASS (enable set, inhibit clear), GM_HOLD (enable set, inhibit set) and GM_GROUND (enable clear). Control writes change the state. GM_PASS→GM_PASS and every transition into GM_PASS reload all eight outputs from their code registers. Every transition into GM_GROUND, including GM_GROUND→GM_GROUND, forces all outputs to the ground code. Transitions into GM_HOLD (from GM_PASS, GM_HOLD or GM_GROUND) leave the outputs where they are. In GM_PASS a code write moves its own channel's output at once. In the other two states a code write is only stored.

Register reads are combinational from the address. Writes take effect at the clock edge that samples `wr_en`. Outputs and strobes are registered and change on that same edge.

Top module: `dac_gate_bank`

## Requirements
- R1: Reset state. Every code register reads 0x3FFF. Every output is 0x3FFF. The gating word reads 0x060006C0. The interrupt word reads 0x00000300. No strobe is active. The machine is in GM_PASS.
- R2: Channel i's code register sits at byte offset 4·i (0x00 to 0x1C). A write stores wdata[15:0], and a read returns it zero-extended.
- R3: In GM_PASS, a write to channel i's code register sets that channel's output to wdata[13:0] after the write edge. The strobe for channel i pulses, and no other output changes.
- R4: In GM_HOLD, entered by a gating write with bit 23 = 1 and bit 26 = 1, code writes are stored but no output changes and no strobe fires.
- R5: A gating write that leaves bit 23 = 0 and bit 26 = 1 loads every output from bits [13:0] of its code register. All eight strobes pulse, even if no value changes.
- R6: A gating write with bit 26 = 0 forces every output to 0x2000 and pulses all strobes. Code writes made afterwards leave the outputs at 0x2000.
- R7: The gating word is at offset 0x54. Only bit 23 (load inhibit) and bit 26 (output enable) take the written value. Every other bit always reads as in 0x060006C0.
- R8: The interrupt word is at offset 0x4C. It reads as (wdata & 0x7FF) | 0x300 from the last write, and bits 31:11 are always 0.
- R9: A write to any other offset changes no register and no output, and a read from any other offset returns 0.
- R10: A strobe lasts exactly one cycle after the load that caused it. Outputs never change without their strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register bus |
| addr | input | 8 | Byte offset for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| dac_code | output | 112 | Channel i code at bits [14·i+13 : 14·i] |
| dac_upd | output | 8 | Per-channel one-cycle update strobe |

## Verification
The bench targets the points where the gating rules interact. One is a code write issued while inhibited, followed by a release. A design that drops stored codes in GM_HOLD would reload stale values, and one that leaks the write would move the output early. Another is a disable that follows a pending code. A design that only gates new writes would leave old codes on the converters instead of the ground code 0x2000. It also writes all-ones and all-zeros patterns to the gating and interrupt words to catch fixed bits that are not re-imposed. It writes to unmapped offsets that share low bits with real registers, which exposes partial address decoding.

// File: rtl/dac_gate_pkg.sv
package dac_gate_pkg;

    localparam logic [7:0]  CTRL_OFS    = 8'h54;
    localparam logic [7:0]  IRQ_OFS     = 8'h4C;
    localparam int          INHIBIT_BIT = 23;
    localparam int          ENABLE_BIT  = 26;
    localparam logic [31:0] CTRL_FIXED  = 32'h0600_06C0;
    localparam logic [31:0] CTRL_WMASK  = (32'd1 << INHIBIT_BIT) | (32'd1 << ENABLE_BIT);
    localparam logic [31:0] IRQ_WMASK   = 32'h0000_07FF;
    localparam logic [31:0] IRQ_FORCED  = 32'h0000_0300;
    localparam logic [13:0] GROUND_CODE = 14'h2000;
    localparam logic [15:0] CODE_RESET  = 16'h3FFF;

    typedef enum logic [1:0] {
        GM_PASS   = 2'd0,
        GM_HOLD   = 2'd1,
        GM_GROUND = 2'd2
    } gate_mode_e;

endpackage

// File: rtl/dac_gate_regs.sv
module dac_gate_regs
    import dac_gate_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CODE_W = 16,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    output logic [NUM_CH*CODE_W-1:0]   code_flat,
    output logic [DATA_W-1:0]          rdata,
    output logic                       code_wr,
    output logic [$clog2(NUM_CH)-1:0]  code_idx,
    output logic                       ctrl_wr,
    output logic [DATA_W-1:0]          ctrl_next
);

    localparam int IDX_W = $clog2(NUM_CH);
    localparam logic [ADDR_W-3:0] NCH_LIM = (ADDR_W-2)'(NUM_CH);

    logic [CODE_W-1:0] code_q [NUM_CH];
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] irq_q;
    logic              code_hit;
    logic              ctrl_hit;
    logic              irq_hit;

    always_comb begin
        code_hit  = (addr[1:0] == 2'b00) && (addr[ADDR_W-1:2] < NCH_LIM);
        ctrl_hit  = (addr == ADDR_W'(CTRL_OFS));
        irq_hit   = (addr == ADDR_W'(IRQ_OFS));
        code_idx  = addr[IDX_W+1:2];
        code_wr   = wr_en && code_hit;
        ctrl_wr   = wr_en && ctrl_hit;
        ctrl_next = (wdata & DATA_W'(CTRL_WMASK)) | (DATA_W'(CTRL_FIXED) & ~DATA_W'(CTRL_WMASK));
    end

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_code
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    code_q[ch] <= CODE_W'(CODE_RESET);
                end else if (code_wr && (code_idx == IDX_W'(ch))) begin
                    code_q[ch] <= wdata[CODE_W-1:0];
                end
            end
            assign code_flat[ch*CODE_W +: CODE_W] = code_q[ch];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= DATA_W'(CTRL_FIXED);
            irq_q  <= DATA_W'(IRQ_FORCED);
        end else begin
            if (ctrl_wr) begin
                ctrl_q <= ctrl_next;
            end
            if (wr_en && irq_hit) begin
                irq_q <= (wdata & DATA_W'(IRQ_WMASK)) | DATA_W'(IRQ_FORCED);
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (code_hit) begin
            rdata = DATA_W'(code_q[code_idx]);
        end else if (ctrl_hit) begin
            rdata = ctrl_q;
        end else if (irq_hit) begin
            rdata = irq_q;
        end
    end

endmodule

// File: rtl/dac_gate_fsm.sv
module dac_gate_fsm
    import dac_gate_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [DATA_W-1:0] ctrl_next,
    input  logic              code_wr,
    output gate_mode_e        mode_q,
    output logic              load_all,
    output logic              ground_all,
    output logic              load_one
);

    gate_mode_e mode_d;
    logic       inh_new;
    logic       en_new;

    always_comb begin
        inh_new = ctrl_next[INHIBIT_BIT];
        en_new  = ctrl_next[ENABLE_BIT];
        mode_d  = mode_q;
        if (ctrl_wr) begin
            unique case (mode_q)
                GM_PASS:   mode_d = !en_new ? GM_GROUND : (inh_new ? GM_HOLD : GM_PASS);
                GM_HOLD:   mode_d = !en_new ? GM_GROUND : (inh_new ? GM_HOLD : GM_PASS);
                GM_GROUND: mode_d = !en_new ? GM_GROUND : (inh_new ? GM_HOLD : GM_PASS);
                default:   mode_d = GM_GROUND;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= GM_PASS;
        end else begin
            mode_q <= mode_d;
        end
    end

    always_comb begin
        load_all   = 1'b0;
        ground_all = 1'b0;
        load_one   = 1'b0;
        if (ctrl_wr) begin
            unique case (mode_d)
                GM_PASS:   load_all   = 1'b1;
                GM_GROUND: ground_all = 1'b1;
                GM_HOLD:   load_all   = 1'b0;
                default:   ground_all = 1'b1;
            endcase
        end else if (code_wr) begin
            unique case (mode_q)
                GM_PASS:   load_one = 1'b1;
                GM_HOLD:   load_one = 1'b0;
                GM_GROUND: load_one = 1'b0;
                default:   load_one = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/dac_gate_outs.sv
module dac_gate_outs
    import dac_gate_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CODE_W = 16,
    parameter int OUT_W  = 14
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load_all,
    input  logic                      ground_all,
    input  logic                      load_one,
    input  logic [$clog2(NUM_CH)-1:0] one_idx,
    input  logic [OUT_W-1:0]          one_code,
    input  logic [NUM_CH*CODE_W-1:0]  code_flat,
    output logic [NUM_CH*OUT_W-1:0]   out_flat,
    output logic [NUM_CH-1:0]         out_stb
);

    localparam int IDX_W = $clog2(NUM_CH);

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
            logic [OUT_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q           <= OUT_W'(CODE_RESET);
                    out_stb[ch] <= 1'b0;
                end else if (ground_all) begin
                    q           <= OUT_W'(GROUND_CODE);
                    out_stb[ch] <= 1'b1;
                end else if (load_all) begin
                    q           <= code_flat[ch*CODE_W +: OUT_W];
                    out_stb[ch] <= 1'b1;
                end else if (load_one && (one_idx == IDX_W'(ch))) begin
                    q           <= one_code;
                    out_stb[ch] <= 1'b1;
                end else begin
                    out_stb[ch] <= 1'b0;
                end
            end
            assign out_flat[ch*OUT_W +: OUT_W] = q;
        end
    endgenerate

endmodule

// File: rtl/dac_gate_bank.sv
module dac_gate_bank
    import dac_gate_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CODE_W = 16,
    parameter int OUT_W  = 14,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rdata,
    output logic [NUM_CH*OUT_W-1:0]  dac_code,
    output logic [NUM_CH-1:0]        dac_upd
);

    localparam int IDX_W = $clog2(NUM_CH);

    logic [NUM_CH*CODE_W-1:0] code_flat;
    logic                     code_wr;
    logic [IDX_W-1:0]         code_idx;
    logic                     ctrl_wr;
    logic [DATA_W-1:0]        ctrl_next;
    gate_mode_e               mode_q;
    logic                     load_all;
    logic                     ground_all;
    logic                     load_one;

    dac_gate_regs #(
        .NUM_CH(NUM_CH), .CODE_W(CODE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .code_flat(code_flat), .rdata(rdata), .code_wr(code_wr),
        .code_idx(code_idx), .ctrl_wr(ctrl_wr), .ctrl_next(ctrl_next)
    );

    dac_gate_fsm #(
        .DATA_W(DATA_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_next(ctrl_next),
        .code_wr(code_wr), .mode_q(mode_q), .load_all(load_all),
        .ground_all(ground_all), .load_one(load_one)
    );

    dac_gate_outs #(
        .NUM_CH(NUM_CH), .CODE_W(CODE_W), .OUT_W(OUT_W)
    ) u_outs (
        .clk(clk), .rst_n(rst_n), .load_all(load_all), .ground_all(ground_all),
        .load_one(load_one), .one_idx(code_idx), .one_code(wdata[OUT_W-1:0]),
        .code_flat(code_flat), .out_flat(dac_code), .out_stb(dac_upd)
    );

endmodule

// File: rtl/dac_gate_bank_chk.sv
module dac_gate_bank_chk
    import dac_gate_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int OUT_W  = 14,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_en,
    input logic [ADDR_W-1:0]       addr,
    input logic [DATA_W-1:0]       wdata,
    input logic [DATA_W-1:0]       rdata,
    input logic [NUM_CH*OUT_W-1:0] dac_code,
    input logic [NUM_CH-1:0]       dac_upd,
    input gate_mode_e              mode_q
);

    // R10
    change_has_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_code) |-> (dac_upd != '0));

    // R10
    strobe_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(dac_upd) <= 1) || (dac_upd == {NUM_CH{1'b1}}));

    // R6
    disable_grounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(CTRL_OFS) && !wdata[ENABLE_BIT])
        |=> (dac_code == {NUM_CH{OUT_W'(GROUND_CODE)}}) && (dac_upd == {NUM_CH{1'b1}}));

    // R4
    hold_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == GM_HOLD && !(wr_en && addr == ADDR_W'(CTRL_OFS))) |=> (dac_upd == '0));

    // R7
    ctrl_fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(CTRL_OFS))
        |-> ((rdata & ~DATA_W'(CTRL_WMASK)) == (DATA_W'(CTRL_FIXED) & ~DATA_W'(CTRL_WMASK))));

    // R8
    irq_forced_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(IRQ_OFS))
        |-> (((rdata & DATA_W'(IRQ_FORCED)) == DATA_W'(IRQ_FORCED)) && ((rdata & ~DATA_W'(IRQ_WMASK)) == '0)));

endmodule

bind dac_gate_bank dac_gate_bank_chk #(
    .NUM_CH(NUM_CH), .OUT_W(OUT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .dac_code(dac_code), .dac_upd(dac_upd), .mode_q(mode_q)
);

// File: tb/dac_gate_bank_tb.sv
module dac_gate_bank_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [7:0]   addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic [111:0] dac_code;
    logic [7:0]   dac_upd;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    logic [15:0] m_code [8];
    logic [13:0] m_out [8];
    logic [7:0]  m_upd;
    logic [31:0] m_ctrl;
    logic [31:0] m_irq;

    always #10 clk = ~clk;

    dac_gate_bank u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .dac_code(dac_code), .dac_upd(dac_upd)
    );

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        if (a[1:0] == 2'b00 && a < 8'h20) return {16'h0, m_code[a[4:2]]};
        if (a == 8'h54) return m_ctrl;
        if (a == 8'h4C) return m_irq;
        return 32'h0;
    endfunction

    function automatic logic [111:0] exp_outs();
        logic [111:0] v;
        for (int i = 0; i < 8; i++) v[i*14 +: 14] = m_out[i];
        return v;
    endfunction

    task automatic check_outs(input string req);
        total++;
        if (dac_code !== exp_outs() || dac_upd !== m_upd) begin
            bad++;
            $display("FAIL %s outputs: code=%h upd=%h expected code=%h upd=%h",
                     req, dac_code, dac_upd, exp_outs(), m_upd);
        end
    endtask

    task automatic check_read(input logic [7:0] a, input string req);
        @(negedge clk);
        wr_en = 1'b0;
        addr  = a;
        m_upd = 8'h00;
        #1;
        total++;
        if (rdata !== exp_read(a)) begin
            bad++;
            $display("FAIL %s read @%h: got %h expected %h", req, a, rdata, exp_read(a));
        end
        check_outs("R10");
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d, input string req);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        m_upd = 8'h00;
        if (a[1:0] == 2'b00 && a < 8'h20) begin
            m_code[a[4:2]] = d[15:0];
            if (m_ctrl[26] && !m_ctrl[23]) begin
                m_out[a[4:2]] = d[13:0];
                m_upd[a[4:2]] = 1'b1;
            end
        end else if (a == 8'h54) begin
            m_ctrl = (d & 32'h0480_0000) | 32'h0200_06C0;
            if (!m_ctrl[26]) begin
                for (int i = 0; i < 8; i++) m_out[i] = 14'h2000;
                m_upd = 8'hFF;
            end else if (!m_ctrl[23]) begin
                for (int i = 0; i < 8; i++) m_out[i] = m_code[i][13:0];
                m_upd = 8'hFF;
            end
        end else if (a == 8'h4C) begin
            m_irq = (d & 32'h7FF) | 32'h300;
        end
        @(negedge clk);
        wr_en = 1'b0;
        check_outs(req);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                total++;
                bad++;
                $display("FAIL watchdog: got timeout expected completion");
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] unm [6];
        unm = '{8'h20, 8'h50, 8'h58, 8'h4D, 8'h03, 8'hFC};
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) begin
            m_code[i] = 16'h3FFF;
            m_out[i]  = 14'h3FFF;
        end
        m_upd  = 8'h00;
        m_ctrl = 32'h0600_06C0;
        m_irq  = 32'h0000_0300;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        for (int i = 0; i < 8; i++) check_read(8'(i * 4), "R1");
        check_read(8'h54, "R1");
        check_read(8'h4C, "R1");

        // R2 R3 pass mode code writes
        for (int i = 0; i < 8; i++) begin
            do_write(8'(i * 4), 32'hABCD_0000 | 32'(16'h1111 * (i + 1)), "R3");
            check_read(8'(i * 4), "R2");
        end

        // R4 hold: store but no output change, then R5 release reloads
        do_write(8'h54, 32'h0480_0000, "R4");
        do_write(8'h08, 32'h0000_FFFF, "R4");
        do_write(8'h1C, 32'h0000_0001, "R4");
        check_read(8'h08, "R4");
        do_write(8'h54, 32'h0400_0000, "R5");
        do_write(8'h54, 32'h0400_0000, "R5");

        // R6 disable then code writes stay at ground
        do_write(8'h00, 32'h0000_1234, "R3");
        do_write(8'h54, 32'h0000_0000, "R6");
        do_write(8'h04, 32'h0000_0777, "R6");
        do_write(8'h54, 32'h0080_0000, "R6");
        do_write(8'h54, 32'h0480_0000, "R4");
        do_write(8'h54, 32'h0400_0000, "R5");

        // R7 R8 all-ones / all-zeros patterns
        do_write(8'h54, 32'hFFFF_FFFF, "R7");
        check_read(8'h54, "R7");
        do_write(8'h54, 32'hFB7F_FFFF, "R7");
        check_read(8'h54, "R7");
        do_write(8'h4C, 32'hFFFF_FFFF, "R8");
        check_read(8'h4C, "R8");
        do_write(8'h4C, 32'h0000_0000, "R8");
        check_read(8'h4C, "R8");
        do_write(8'h54, 32'h0400_0000, "R5");

        // R9 unmapped writes and reads
        for (int k = 0; k < 6; k++) begin
            do_write(unm[k], 32'hFFFF_FFFF, "R9");
            check_read(unm[k], "R9");
            check_read(8'h54, "R9");
            check_read(8'h4C, "R9");
            for (int i = 0; i < 8; i++) check_read(8'(i * 4), "R9");
        end

        // Random mix
        for (int n = 0; n < 600; n++) begin
            int kind;
            logic [31:0] d;
            kind = int'($urandom % 10);
            d = $urandom;
            if (kind < 4) begin
                do_write(8'(($urandom % 8) * 4), d, "R3");
            end else if (kind < 6) begin
                if (($urandom % 4) != 0) d[26] = 1'b1;
                do_write(8'h54, d, "R5");
            end else if (kind == 6) begin
                do_write(8'h4C, d, "R8");
            end else if (kind == 7) begin
                do_write(unm[$urandom % 6], d, "R9");
            end else begin
                logic [7:0] ra;
                case ($urandom % 4)
                    0: ra = 8'h54;
                    1: ra = 8'h4C;
                    2: ra = unm[$urandom % 6];
                    default: ra = 8'(($urandom % 8) * 4);
                endcase
                check_read(ra, "R2");
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule